// File: doc/BRIEF.md
# Triple-Lane Result Voter with Fault Tracking

This block takes the results of three compute lanes that work the same operation on their own and turns them into one trusted word. Each lane hands over its result with a one-cycle valid strobe, in any order and in any cycle. Once all three results are in, the block issues the bitwise majority and tells any lane that disagreed to compute its result again. If no two lanes agree, the block marks the result as uncorrectable and sends the recompute request to all three lanes.

A small error counter for each lane records how often that lane has been outvoted recently. A miscompare raises the count and an agreeing result lowers it, so a single upset fades away. A lane that keeps failing reaches a software-set limit, receives a one-cycle reset pulse and starts again from zero. A watchdog watches the stream of voted results. If none arrives for a fixed number of cycles, it holds a hard-reset output high for a fixed number of cycles and clears the block's own state.

Top module: `lane_voter`

## Requirements
- R1: Each lane's first valid result is held until all three lanes have delivered. A further valid from a lane that is already held is ignored until the vote. The held flags appear in status bits [2:0] (bit i = lane i, lanes a, b, c = 0, 1, 2).
- R2: In the cycle after the clock edge where the third result becomes present, out_valid is high for one cycle and out_data carries the bitwise majority of the three words.
- R3: If exactly one lane differs from the other two, only that lane's redo bit is high, in the same cycle as out_valid. If all three lanes agree, redo is zero. Outside a result cycle, redo is zero.
- R4: If all three words differ from one another, uncorrectable and all three redo bits are high with the result.
- R5: At each vote, the counter of every miscomparing lane rises by one, saturating at its maximum. The counter of every agreeing lane falls by one, stopping at zero. Lane i's counter appears at status[3+i*CNT_W +: CNT_W] and changes only at a vote or a hard reset.
- R6: When a miscompare would raise a lane's count to err_limit or above, that lane's lane_rst bit pulses with the result and its counter returns to zero. With err_limit of 0, every miscompare triggers the pulse.
- R7: After WDOG_CYCLES consecutive clock edges with no vote, hard_rst goes high for exactly HOLD_CYCLES cycles. Each vote restarts the count.
- R8: A hard reset clears the held results and all counters. Lane valids are ignored while hard_rst is high, and no result is produced then.
- R9: After rst_n is released, every output and the status word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | W | Lane 0 result |
| b_data | input | W | Lane 1 result |
| c_data | input | W | Lane 2 result |
| in_valid | input | 3 | Per-lane result strobe, bit i = lane i |
| err_limit | input | CNT_W | Miscompare count that triggers a lane reset |
| out_valid | output | 1 | Voted result strobe |
| out_data | output | W | Bitwise majority result |
| redo | output | 3 | Per-lane recompute request |
| uncorrectable | output | 1 | No two lanes agreed |
| lane_rst | output | 3 | Per-lane reset pulse |
| hard_rst | output | 1 | Watchdog hard reset |
| status | output | 3*CNT_W+3 | Lane counters and held flags |

## Verification
The vote is driven with several patterns, each of which tells a different fault apart:
- Three equal words confirm that a clean vote raises no request.
- A single corrupted lane in each position shows that the minority decode points at the right lane.
- Three pairwise different words separate the uncorrectable path from an ordinary single miscompare.
- Arrival orders are varied: all lanes together, staggered, and with a repeated strobe from a lane that is already held. These show that the vote waits for the last lane and keeps the first word.
- A sequence of failures mixed with agreements on one lane tells the decrement and clear rules apart from a plain counter.
- The watchdog is timed to the exact cycle from the last vote. Its pulse length is measured, and stray lane strobes during the pulse are shown to leave nothing behind.

// File: rtl/lane_voter.sv
module lane_voter #(
  parameter int W           = 32,
  parameter int CNT_W       = 4,
  parameter int WDOG_CYCLES = 100000,
  parameter int HOLD_CYCLES = 16,
  localparam int WD_W = $clog2(WDOG_CYCLES + 1),
  localparam int HR_W = $clog2(HOLD_CYCLES + 1),
  localparam int ST_W = 3 * CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_data,
  input  logic [W-1:0]     b_data,
  input  logic [W-1:0]     c_data,
  input  logic [2:0]       in_valid,
  input  logic [CNT_W-1:0] err_limit,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [2:0]       redo,
  output logic             uncorrectable,
  output logic [2:0]       lane_rst,
  output logic             hard_rst,
  output logic [ST_W-1:0]  status
);

  logic [2:0][W-1:0]     din, held_q, cur;
  logic [2:0]            full_q, have, mis, trip;
  logic [2:0][CNT_W-1:0] cnt_q;
  logic [2:0][CNT_W:0]   bump;
  logic [W-1:0]          maj;
  logic [WD_W-1:0]       wd_q;
  logic [HR_W-1:0]       hr_q;
  logic                  hr_on, fire, expire, clear, e01, e02, e12, split;

  assign din    = {c_data, b_data, a_data};
  assign hr_on  = (hr_q != '0);
  assign have   = full_q | (in_valid & {3{~hr_on}});
  assign fire   = (&have) && !hr_on;
  assign expire = !fire && !hr_on && (wd_q == WD_W'(WDOG_CYCLES - 1));
  assign clear  = hr_on || expire;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      cur[i]  = full_q[i] ? held_q[i] : din[i];
      bump[i] = {1'b0, cnt_q[i]} + {{CNT_W{1'b0}}, 1'b1};
    end
  end

  assign maj   = (cur[0] & cur[1]) | (cur[0] & cur[2]) | (cur[1] & cur[2]);
  assign e01   = (cur[0] == cur[1]);
  assign e02   = (cur[0] == cur[2]);
  assign e12   = (cur[1] == cur[2]);
  assign split = !e01 && !e02 && !e12;
  assign mis   = {split | (e01 & ~e02), split | (e02 & ~e01), split | (e12 & ~e01)};

  always_comb begin
    for (int i = 0; i < 3; i++)
      trip[i] = fire && mis[i] && (bump[i] >= {1'b0, err_limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      redo          <= '0;
      uncorrectable <= 1'b0;
      lane_rst      <= '0;
    end else begin
      out_valid     <= fire;
      redo          <= fire ? mis : 3'b000;
      uncorrectable <= fire && split;
      lane_rst      <= trip;
      if (fire) out_data <= maj;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      held_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      full_q <= '0;
      cnt_q  <= '0;
    end else if (fire) begin
      full_q <= '0;
      for (int i = 0; i < 3; i++) begin
        if (trip[i])
          cnt_q[i] <= '0;
        else if (mis[i]) begin
          if (cnt_q[i] != {CNT_W{1'b1}}) cnt_q[i] <= bump[i][CNT_W-1:0];
        end else if (cnt_q[i] != '0)
          cnt_q[i] <= cnt_q[i] - 1'b1;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (in_valid[i] && !full_q[i]) begin
          full_q[i] <= 1'b1;
          held_q[i] <= din[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= '0;
      hr_q <= '0;
    end else begin
      if (fire || clear) wd_q <= '0;
      else               wd_q <= wd_q + 1'b1;
      if (expire)        hr_q <= HR_W'(HOLD_CYCLES);
      else if (hr_on)    hr_q <= hr_q - 1'b1;
    end
  end

  assign hard_rst = hr_on;
  assign status   = {cnt_q, full_q};

endmodule

// File: rtl/lane_voter_chk.sv
module lane_voter_chk #(
  parameter int ST_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_valid,
  input logic [2:0]      redo,
  input logic            uncorrectable,
  input logic [2:0]      lane_rst,
  input logic            hard_rst,
  input logic [ST_W-1:0] status
);

  p_redo_with_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|redo) |-> out_valid);

  p_single_minority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !uncorrectable) |-> ($countones(redo) <= 1));

  p_split_redo_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> (redo == 3'b111));

  p_counters_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !hard_rst) |-> $stable(status[ST_W-1:3]));

  p_reset_needs_redo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_rst) |-> ((lane_rst & ~redo) == 3'b000));

  p_quiet_in_hard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |-> (!out_valid && status == '0));

endmodule

bind lane_voter lane_voter_chk #(.ST_W(ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .redo(redo),
  .uncorrectable(uncorrectable), .lane_rst(lane_rst), .hard_rst(hard_rst),
  .status(status)
);

// File: tb/lane_voter_tb_top.sv
`timescale 1ns/1ps
module lane_voter_tb_top;
  localparam int W = 16, CW = 3, WD = 40, HOLD = 5, SW = 3 * CW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0, c_data = '0;
  logic [2:0] in_valid = '0;
  logic [CW-1:0] err_limit = CW'(3);
  logic out_valid, uncorrectable, hard_rst;
  logic [W-1:0] out_data;
  logic [2:0] redo, lane_rst;
  logic [SW-1:0] status;

  lane_voter #(.W(W), .CNT_W(CW), .WDOG_CYCLES(WD), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_data(a_data), .b_data(b_data), .c_data(c_data),
    .in_valid(in_valid), .err_limit(err_limit), .out_valid(out_valid),
    .out_data(out_data), .redo(redo), .uncorrectable(uncorrectable),
    .lane_rst(lane_rst), .hard_rst(hard_rst), .status(status));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [W-1:0]  data;
    logic [2:0]    redo;
    logic          unc;
    logic [2:0]    rst;
    logic [SW-1:0] st;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  int mcnt[3] = '{0, 0, 0};
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [2:0] v, input logic [W-1:0] a, b, c);
    @(negedge clk);
    in_valid = v; a_data = a; b_data = b; c_data = c;
  endtask

  task automatic vote(input logic [W-1:0] a, b, c, input int mode);
    exp_t e;
    logic [W-1:0] w[3];
    logic [2:0] mis;
    logic e01, e02, e12, spl;
    w[0] = a; w[1] = b; w[2] = c;
    e01 = (a == b); e02 = (a == c); e12 = (b == c);
    spl = !e01 && !e02 && !e12;
    mis[0] = spl || (e12 && !e01);
    mis[1] = spl || (e02 && !e01);
    mis[2] = spl || (e01 && !e02);
    e.data = (a & b) | (a & c) | (b & c);
    e.redo = mis; e.unc = spl; e.rst = '0;
    for (int i = 0; i < 3; i++) begin
      if (mis[i]) begin
        if (mcnt[i] + 1 >= int'(err_limit)) begin e.rst[i] = 1'b1; mcnt[i] = 0; end
        else if (mcnt[i] < (1 << CW) - 1) mcnt[i]++;
      end else if (mcnt[i] > 0) mcnt[i]--;
    end
    e.st = {CW'(mcnt[2]), CW'(mcnt[1]), CW'(mcnt[0]), 3'b000};
    sb.push_back(e);
    if (mode == 0) present(3'b111, a, b, c);
    else if (mode == 1) begin
      present(3'b100, '0, '0, c);
      present(3'b001, a, '0, '0);
      present(3'b010, '0, b, '0);
    end else begin
      present(3'b010, '0, b, '0);
      present(3'b001, a, '0, '0);
      present(3'b001, ~a, '0, '0);
      chk("R1 held flags", 64'(status[2:0]), 64'(3'b011));
      present(3'b100, '0, '0, c);
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) chk("R2 unexpected result", 64'(1), 64'(0));
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2 majority", 64'(out_data), 64'(e.data));
          chk("R3 redo", 64'(redo), 64'(e.redo));
          chk("R4 uncorrectable", 64'(uncorrectable), 64'(e.unc));
          chk("R6 lane_rst", 64'(lane_rst), 64'(e.rst));
          chk("R5 counters", 64'(status), 64'(e.st));
        end
      end else if (redo != 0 || lane_rst != 0 || uncorrectable) begin
        chk("R3 outputs idle", 64'({redo, lane_rst, uncorrectable}), 64'(0));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: bench did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset outputs", 64'({out_valid, redo, uncorrectable, lane_rst, hard_rst}), 64'(0));
    chk("R9 reset status", 64'(status), 64'(0));

    vote(16'h1234, 16'h1234, 16'h1234, 0);
    vote(16'hA5A5, 16'hA5A5, 16'h0F0F, 1);
    vote(16'h5555, 16'h5555, 16'h7777, 2);
    vote(16'h0001, 16'h0001, 16'h0001, 0);
    vote(16'h00FF, 16'h00FF, 16'hFF00, 0);
    vote(16'hC3C3, 16'hC3C3, 16'h0000, 1);
    vote(16'h8000, 16'h0F00, 16'h0F00, 0);
    vote(16'h2222, 16'h3333, 16'h2222, 2);
    vote(16'h00F0, 16'h0F00, 16'hF000, 0);
    err_limit = CW'(0);
    vote(16'hBEEF, 16'h0000, 16'hBEEF, 0);
    err_limit = CW'(3);
    vote(16'h4444, 16'h4444, 16'h6666, 0);
    repeat (WD - 1) @(negedge clk);
    chk("R7 not yet expired", 64'(hard_rst), 64'(0));
    @(negedge clk);
    chk("R7 expired", 64'(hard_rst), 64'(1));
    chk("R8 counters cleared", 64'(status), 64'(0));
    mcnt = '{0, 0, 0};
    in_valid = 3'b011; a_data = 16'h9999; b_data = 16'h9999;
    @(negedge clk);
    in_valid = 3'b000;
    repeat (HOLD - 2) @(negedge clk);
    chk("R7 held length", 64'(hard_rst), 64'(1));
    @(negedge clk);
    chk("R7 released", 64'(hard_rst), 64'(0));
    chk("R8 strobes ignored", 64'(status), 64'(0));
    vote(16'h7E7E, 16'h7E7E, 16'h7E7E, 1);
    repeat (2) @(negedge clk);
    chk("R2 all results seen", 64'(sb.size()), 64'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule